// File: doc/BRIEF.md
# Flash Address Translator for Non-Power-of-Two Pages

This block turns a flat byte address into the address layout that a serial flash uses when its pages are 264 or 528 bytes long. The flat address is divided by the page size. The quotient (page number) is placed above a byte-offset field whose width is the ceiling log2 of the page size: 9 bits for 264-byte pages and 10 bits for 528-byte pages. The remainder (byte offset) fills that field.

When the device has been switched to binary page sizes (256 or 512 bytes), the address needs no repacking and is forwarded as is. The block also reports the erase-sector index, which is the page number divided by eight. It flags any address that lies beyond the device capacity.

A requester presents an address with a valid/ready handshake. A one-cycle done pulse marks the result. The divide is a restoring divider that produces one quotient bit per cycle.

Top module: `flash_addr_xlate`

## Requirements
- R1: After reset, in_ready is 1, and done, dev_addr, sector_idx and out_of_range are all 0.
- R2: A request is taken on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle until the cycle in which done is 1.
- R3: With binary_mode=0, the low field of dev_addr holds the address modulo the page size. The field is bits [8:0] when wide_page=0 (264-byte pages) and bits [9:0] when wide_page=1 (528-byte pages).
- R4: With binary_mode=0, the page number (address divided by the page size) sits directly above that field: from bit 9 for 264-byte pages and from bit 10 for 528-byte pages.
- R5: With binary_mode=1, dev_addr equals the request address, zero-extended.
- R6: sector_idx is the page number divided by 8. In binary mode the page number is the address shifted right by 8 (wide_page=0) or by 9 (wide_page=1).
- R7: out_of_range is 1 when the page number is NUM_PAGES or more. While it is 1, dev_addr and sector_idx are 0.
- R8: done rises 1 cycle after the accepting edge in binary mode, and ADDR_W+1 cycles after it otherwise.
- R9: done lasts exactly one cycle. The result outputs keep their values until the next result.
- R10: in_valid, in_addr, binary_mode and wide_page have no effect while in_ready is 0; the result is that of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | ADDR_W | Flat byte address |
| binary_mode | input | 1 | 1: binary page sizes, address forwarded |
| wide_page | input | 1 | 0: 264/256-byte pages, 1: 528/512-byte pages |
| done | output | 1 | One-cycle result strobe |
| dev_addr | output | OUT_W | Repacked device address |
| sector_idx | output | ADDR_W-3 | Erase-sector index (page / 8) |
| out_of_range | output | 1 | Address beyond device capacity |

## Verification
The bench sweeps addresses densely in all four mode combinations. It also visits the last byte of every page, the first byte of the next page, and the two addresses on either side of the capacity limit.

Each of these cases catches a specific fault:
- A remainder that is off by one page, or an off-by-one in the restoring step, shows up at page edges as a wrong offset or a skipped page.
- A swapped 9/10-bit shift corrupts every page above zero in one of the two sizes.
- A misplaced capacity compare leaks a nonzero address for the first out-of-range page.

Requests that are driven while the block is busy check that a careless ready path does not let a second request overwrite the one being computed.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the flash address translator.
// Assumes page sizes are not powers of two and that each binary size is
// the next lower power of two.
package xlate_pkg;
    localparam int PAGE_SMALL = 264;
    localparam int PAGE_LARGE = 528;
    localparam int OFS_SMALL  = $clog2(PAGE_SMALL);   // offset field width, 264-byte pages
    localparam int OFS_LARGE  = $clog2(PAGE_LARGE);   // offset field width, 528-byte pages
    localparam int SECTOR_LOG = 3;                    // 8 pages per erase sector
    localparam int DIVISOR_W  = $clog2(PAGE_LARGE + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DIV  = 2'd2
    } xlate_state_e;
endpackage

// File: rtl/xlate_divider.sv
// Restoring divider, one quotient bit per cycle.
// A start pulse loads the dividend and divisor. After N cycles, fin pulses
// for one cycle with quo/rem valid. quo/rem then stay put until the next start.
// Assumes start is never raised while a divide is running.
module xlate_divider #(
    parameter int N = 22,
    parameter int D = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         fin,
    output logic [N-1:0] quo,
    output logic [D-1:0] rem
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic          busy;
    logic [CW-1:0] cnt;
    logic [D-1:0]  dsr_q;
    logic [D:0]    shifted;
    logic [D:0]    diff;
    logic          fits;
    logic [D-1:0]  next_rem;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        shifted  = {rem, quo[N-1]};
        diff     = shifted - {1'b0, dsr_q};
        fits     = ~diff[D];
        next_rem = fits ? diff[D-1:0] : shifted[D-1:0];
    end

    // Iteration register: load on start, shift one bit per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            fin   <= 1'b0;
            cnt   <= '0;
            quo   <= '0;
            rem   <= '0;
            dsr_q <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt   <= '0;
                quo   <= dividend;
                rem   <= '0;
                dsr_q <= divisor;
            end else if (busy) begin
                rem <= next_rem;
                quo <= {quo[N-2:0], fits};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(N - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    // R10: the controller never restarts a divide that is in flight.
    a_r10_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    // R3: a finished remainder is always below the divisor.
    a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem < dsr_q));
endmodule

// File: rtl/xlate_pack.sv
// Combinational repacking of page/offset and the capacity check.
// Binary mode takes the page from an address shift; the other mode takes
// it from the divider. Assumes quo/rem belong to the address presented.
module xlate_pack
    import xlate_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int OUT_W     = 24,
    parameter int NUM_PAGES = 4096
) (
    input  logic                         binary_mode,
    input  logic                         wide_page,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [ADDR_W-1:0]            quo,
    input  logic [DIVISOR_W-1:0]         rem,
    output logic [OUT_W-1:0]             dev,
    output logic [ADDR_W-SECTOR_LOG-1:0] sector,
    output logic                         oor
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_PAGES);

    logic [OUT_W-1:0]  packed_v [2];
    logic [ADDR_W-1:0] binpage_v [2];
    logic [ADDR_W-1:0] page;

    // One packing and one binary page extractor per page size.
    for (genvar g = 0; g < 2; g++) begin : g_size
        localparam int OW = (g == 0) ? OFS_SMALL : OFS_LARGE;
        assign packed_v[g]  = (OUT_W'(quo) << OW) | OUT_W'(rem);
        assign binpage_v[g] = addr >> (OW - 1);
    end

    // Select page source, check capacity, and choose the output form.
    always_comb begin
        page   = binary_mode ? binpage_v[wide_page] : quo;
        oor    = ({1'b0, page} >= LIMIT);
        sector = oor ? '0 : page[ADDR_W-1:SECTOR_LOG];
        if (oor)              dev = '0;
        else if (binary_mode) dev = OUT_W'(addr);
        else                  dev = packed_v[wide_page];
    end
endmodule

// File: rtl/flash_addr_xlate.sv
// Flash address translator top: handshake, sequencing and result registers.
// A request is taken when idle. Binary-mode requests finish in one cycle;
// other requests run the restoring divider for ADDR_W cycles. Assumes
// OUT_W is wide enough for the shifted page plus offset.
module flash_addr_xlate
    import xlate_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int OUT_W     = 24,
    parameter int NUM_PAGES = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic                    binary_mode,
    input  logic                    wide_page,
    output logic                    done,
    output logic [OUT_W-1:0]        dev_addr,
    output logic [ADDR_W-4:0]       sector_idx,
    output logic                    out_of_range
);
    localparam int SEC_W = ADDR_W - SECTOR_LOG;

    xlate_state_e         state;
    logic [ADDR_W-1:0]    addr_q;
    logic                 bin_q;
    logic                 wide_q;
    logic                 accept;
    logic                 div_start;
    logic                 div_fin;
    logic                 load;
    logic [DIVISOR_W-1:0] divisor;
    logic [ADDR_W-1:0]    quo;
    logic [DIVISOR_W-1:0] rem;
    logic [OUT_W-1:0]     dev_c;
    logic [SEC_W-1:0]     sec_c;
    logic                 oor_c;

    // Handshake and control strobes.
    always_comb begin
        in_ready  = (state == ST_IDLE);
        accept    = in_valid && in_ready;
        div_start = accept && !binary_mode;
        divisor   = wide_page ? DIVISOR_W'(PAGE_LARGE) : DIVISOR_W'(PAGE_SMALL);
        load      = (state == ST_PASS) || ((state == ST_DIV) && div_fin);
    end

    xlate_divider #(.N(ADDR_W), .D(DIVISOR_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (in_addr),
        .divisor  (divisor),
        .fin      (div_fin),
        .quo      (quo),
        .rem      (rem)
    );

    xlate_pack #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .NUM_PAGES(NUM_PAGES)) u_pack (
        .binary_mode (bin_q),
        .wide_page   (wide_q),
        .addr        (addr_q),
        .quo         (quo),
        .rem         (rem),
        .dev         (dev_c),
        .sector      (sec_c),
        .oor         (oor_c)
    );

    // Sequencer: capture request, wait for result, register outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            addr_q       <= '0;
            bin_q        <= 1'b0;
            wide_q       <= 1'b0;
            done         <= 1'b0;
            dev_addr     <= '0;
            sector_idx   <= '0;
            out_of_range <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    addr_q <= in_addr;
                    bin_q  <= binary_mode;
                    wide_q <= wide_page;
                    state  <= binary_mode ? ST_PASS : ST_DIV;
                end
                ST_PASS, ST_DIV: if (load) begin
                    dev_addr     <= dev_c;
                    sector_idx   <= sec_c;
                    out_of_range <= oor_c;
                    done         <= 1'b1;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: ready drops right after a request is taken.
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R9: done is a single-cycle strobe.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: binary-mode requests finish one cycle after acceptance.
    a_r8_binary_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && binary_mode) |=> ##1 done);

    // R3: a repacked offset field never reaches the page size.
    a_r3_offset_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bin_q && !out_of_range) |->
            (wide_q ? (dev_addr[OFS_LARGE-1:0] < OFS_LARGE'(PAGE_LARGE))
                    : (dev_addr[OFS_SMALL-1:0] < OFS_SMALL'(PAGE_SMALL))));

    // R7: an out-of-range result carries no address or sector.
    a_r7_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (dev_addr == '0 && sector_idx == '0));
endmodule

// File: tb/flash_addr_xlate_tb_top.sv
// Sweep bench for the flash address translator on a small device.
module flash_addr_xlate_tb_top;
    localparam int ADDR_W    = 14;
    localparam int OUT_W     = 24;
    localparam int NUM_PAGES = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              binary_mode = 1'b0;
    logic              wide_page = 1'b0;
    logic              done;
    logic [OUT_W-1:0]  dev_addr;
    logic [ADDR_W-4:0] sector_idx;
    logic              out_of_range;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_addr_xlate #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .NUM_PAGES(NUM_PAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .binary_mode(binary_mode), .wide_page(wide_page),
        .done(done), .dev_addr(dev_addr), .sector_idx(sector_idx),
        .out_of_range(out_of_range)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input int a, input bit bin, input bit wide,
                         output longint ed, output longint es, output longint eo);
        int psz, sh, bsh, page;
        psz  = wide ? 528 : 264;
        sh   = wide ? 10 : 9;
        bsh  = wide ? 9 : 8;
        page = bin ? (a >> bsh) : (a / psz);
        eo   = (page >= NUM_PAGES) ? 1 : 0;
        ed   = eo ? 0 : (bin ? a : ((page << sh) | (a % psz)));
        es   = eo ? 0 : (page >> 3);
    endtask

    task automatic run_one(input int a, input bit bin, input bit wide, input bit junk);
        longint ed, es, eo, held;
        int lat;
        bit got;
        model(a, bin, wide, ed, es, eo);
        @(negedge clk);
        chk("R2 ready before request", in_ready, 1);
        in_addr = ADDR_W'(a); binary_mode = bin; wide_page = wide; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            in_addr = ADDR_W'(a ^ 'h2a5); wide_page = ~wide; binary_mode = 1'b1;
        end else begin
            in_valid = 1'b0;
        end
        chk("R2 ready low after accept", in_ready, bin ? 0 : 0);
        lat = 0; got = 0;
        while (!got && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) got = 1;
            else if (!(junk && lat < 4)) in_valid = 1'b0;
        end
        in_valid = 1'b0;
        chk(junk ? "R10 addr with busy-time inputs" : (bin ? "R5 dev_addr" : "R3/R4 dev_addr"),
            dev_addr, ed);
        chk("R6 sector_idx", sector_idx, es);
        chk("R7 out_of_range", out_of_range, eo);
        chk("R8 latency", lat, bin ? 1 : ADDR_W + 1);
        held = dev_addr;
        @(posedge clk);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 dev_addr held", dev_addr, held);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 ready in reset", in_ready, 1);
        chk("R1 done in reset", done, 0);
        chk("R1 dev_addr in reset", dev_addr, 0);
        chk("R1 sector in reset", sector_idx, 0);
        chk("R1 oor in reset", out_of_range, 0);
        rst_n = 1'b1;

        // Page edges and capacity edges, repacked mode.
        for (int w = 0; w < 2; w++) begin
            int psz = (w != 0) ? 528 : 264;
            for (int k = 0; k <= NUM_PAGES + 1; k++) begin
                if (k > 0) run_one(k * psz - 1, 1'b0, w[0], 1'b0);
                run_one(k * psz, 1'b0, w[0], (k == 5));
            end
            run_one((1 << ADDR_W) - 1, 1'b0, w[0], 1'b0);
        end
        // Binary-mode capacity edges.
        for (int w = 0; w < 2; w++) begin
            int cap = NUM_PAGES << ((w != 0) ? 9 : 8);
            run_one(cap - 1, 1'b1, w[0], 1'b0);
            run_one(cap, 1'b1, w[0], 1'b0);
        end
        // Dense sweeps.
        for (int w = 0; w < 2; w++)
            for (int a = 0; a < 9000; a += 11)
                run_one(a, 1'b0, w[0], 1'b0);
        for (int w = 0; w < 2; w++)
            for (int a = 0; a < (1 << ADDR_W); a += 3)
                run_one(a, 1'b1, w[0], 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule